// File: doc/BRIEF.md
# LPDDR2 Power-Up Bring-Up Sequencer

This block takes a low-power DDR2 memory from power-on to normal operation in hardware. Software does not step through the commands. After a one-cycle `start` pulse it sends a fixed series of commands to a command issue unit over a request/acknowledge interface. For each command it presents a command type, a mode-register address and write data, and it holds them steady until the issue unit acknowledges. Between some commands it waits a minimum time. Each wait is counted in controller clock cycles, computed from a clock-frequency parameter and rounded up.

The order is as follows:
1. A clock-start NOP.
2. A CKE-raising NOP.
3. A reset written to mode register 63.
4. ZQ calibration through mode register 10.
5. Configuration writes to mode registers 1, 2, 3 and 16.
6. A NOP.
7. An identification read-back of mode registers 5, 6, 8 and 0. The read data returned with each acknowledge is captured on dedicated outputs.
8. A normal-mode command.

After the normal-mode command the block loads the refresh interval, enables refresh and raises `done`.

Top module: `lpddr2_bringup`

## Requirements
- R1: After reset the block is idle. `cmd_req`, `clk_en`, `cke`, `done`, `refresh_en`, `refresh_interval`, `zq_type` and all ID outputs are 0. No request appears until `start` is pulsed.
- R2: Command type codes are NOP=0, MRW=1, MRR=2, NORMAL=3. The first two commands are NOPs with address 0 and data 0. `clk_en` rises on the first NOP's acknowledge. `cke` rises on the second NOP's acknowledge. The second NOP is requested no earlier than W_CKE cycles after the first acknowledge.
- R3: The third command is MRW to address 63 with data 0x00. It is requested no earlier than W_RST cycles after the second NOP's acknowledge. The next command follows no earlier than W_INIT5 cycles after its acknowledge.
- R4: The fourth command is MRW to address 10 with data 0xFF. `zq_type` is 3 while that request is pending, and 2 from its acknowledge onward. The MR1 write is requested no earlier than W_ZQ cycles after that acknowledge.
- R5: Next come MRW commands to addresses 1, 2, 3 and 16, in that order, carrying `cfg_mr1`, `cfg_mr2`, `cfg_mr3` and `cfg_mr16` respectively.
- R6: A request is held, with type, address and data stable, until `cmd_ack`.
- R7: Next comes a NOP, then MRR commands (data 0) to addresses 5, 6, 8 and 0, in that order. The `cmd_rdata` value at each acknowledge is captured on `id_mfr`, `id_rev`, `id_org` and `id_info` respectively.
- R8: The last command is NORMAL (address 0, data 0). On its acknowledge, `done` and `refresh_en` go high and `refresh_interval` takes `cfg_refi`.
- R9: `refresh_en` is never high while `done` is low.
- R10: `done` stays high until reset. A `start` pulse during the sequence or after `done` has no effect.
- R11: Each wait W equals ceil(t_ns × CLK_MHZ / 1000), with a minimum of 1. At the defaults (100 MHz) this gives W_CKE=10, W_RST=20000, W_INIT5=1000 and W_ZQ=100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only in idle |
| cfg_mr1 | input | 8 | Data for MR1 write |
| cfg_mr2 | input | 8 | Data for MR2 write (CAS latency) |
| cfg_mr3 | input | 8 | Data for MR3 write (drive strength, slew) |
| cfg_mr16 | input | 8 | Data for MR16 write (partial-array refresh) |
| cfg_refi | input | REFI_W | Refresh interval loaded at the end |
| cmd_req | output | 1 | Command request |
| cmd_type | output | 2 | Command type code |
| cmd_addr | output | 8 | Mode-register address |
| cmd_wdata | output | 8 | Mode-register write data |
| cmd_ack | input | 1 | Acknowledge from issue unit |
| cmd_rdata | input | 8 | Read data valid with acknowledge of MRR |
| clk_en | output | 1 | Memory clock enable |
| cke | output | 1 | Clock-enable pin level |
| zq_type | output | 2 | Calibration type code |
| id_mfr | output | 8 | Captured MR5 |
| id_rev | output | 8 | Captured MR6 |
| id_org | output | 8 | Captured MR8 |
| id_info | output | 8 | Captured MR0 |
| done | output | 1 | Normal mode reached |
| refresh_en | output | 1 | Refresh enabled |
| refresh_interval | output | REFI_W | Loaded refresh interval |

## Verification
The hardest case to reach from the ports is a slow issue unit: a request held across several cycles while the step counter stays fixed, at both the waited steps and the back-to-back mode-register steps. The bench runs a second full sequence in which the responder delays every acknowledge by three cycles. On every cycle a request is pending, it compares the presented fields against those first seen for that request. The long reset pause is run at its real length, so the wait boundaries are measured as exact cycle gaps between an acknowledge and the next request.

// File: rtl/lpddr2_bringup.sv
module lpddr2_bringup #(
  parameter int CLK_MHZ    = 100,
  parameter int T_CKE_NS   = 100,
  parameter int T_RST_NS   = 200000,
  parameter int T_INIT5_NS = 10000,
  parameter int T_ZQ_NS    = 1000,
  parameter int REFI_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        cfg_mr1,
  input  logic [7:0]        cfg_mr2,
  input  logic [7:0]        cfg_mr3,
  input  logic [7:0]        cfg_mr16,
  input  logic [REFI_W-1:0] cfg_refi,
  output logic              cmd_req,
  output logic [1:0]        cmd_type,
  output logic [7:0]        cmd_addr,
  output logic [7:0]        cmd_wdata,
  input  logic              cmd_ack,
  input  logic [7:0]        cmd_rdata,
  output logic              clk_en,
  output logic              cke,
  output logic [1:0]        zq_type,
  output logic [7:0]        id_mfr,
  output logic [7:0]        id_rev,
  output logic [7:0]        id_org,
  output logic [7:0]        id_info,
  output logic              done,
  output logic              refresh_en,
  output logic [REFI_W-1:0] refresh_interval
);

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int W_CKE   = cyc_of(T_CKE_NS);
  localparam int W_RST   = cyc_of(T_RST_NS);
  localparam int W_INIT5 = cyc_of(T_INIT5_NS);
  localparam int W_ZQ    = cyc_of(T_ZQ_NS);
  localparam int W_MAX01 = (W_CKE > W_RST) ? W_CKE : W_RST;
  localparam int W_MAX23 = (W_INIT5 > W_ZQ) ? W_INIT5 : W_ZQ;
  localparam int W_MAX   = (W_MAX01 > W_MAX23) ? W_MAX01 : W_MAX23;
  localparam int CNT_W   = $clog2(W_MAX + 1);
  localparam int LAST    = 13;

  localparam logic [1:0] T_NOP = 2'd0, T_MRW = 2'd1, T_MRR = 2'd2, T_NORM = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_t;

  state_t           state;
  logic [3:0]       step;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wait_len;

  always_comb begin
    cmd_type  = T_NOP;
    cmd_addr  = 8'd0;
    cmd_wdata = 8'd0;
    wait_len  = '0;
    case (step)
      4'd0:  wait_len = CNT_W'(W_CKE);
      4'd1:  wait_len = CNT_W'(W_RST);
      4'd2:  begin cmd_type = T_MRW; cmd_addr = 8'd63; wait_len = CNT_W'(W_INIT5); end
      4'd3:  begin cmd_type = T_MRW; cmd_addr = 8'd10; cmd_wdata = 8'hFF; wait_len = CNT_W'(W_ZQ); end
      4'd4:  begin cmd_type = T_MRW; cmd_addr = 8'd1;  cmd_wdata = cfg_mr1;  end
      4'd5:  begin cmd_type = T_MRW; cmd_addr = 8'd2;  cmd_wdata = cfg_mr2;  end
      4'd6:  begin cmd_type = T_MRW; cmd_addr = 8'd3;  cmd_wdata = cfg_mr3;  end
      4'd7:  begin cmd_type = T_MRW; cmd_addr = 8'd16; cmd_wdata = cfg_mr16; end
      4'd8:  cmd_type = T_NOP;
      4'd9:  begin cmd_type = T_MRR; cmd_addr = 8'd5; end
      4'd10: begin cmd_type = T_MRR; cmd_addr = 8'd6; end
      4'd11: begin cmd_type = T_MRR; cmd_addr = 8'd8; end
      4'd12: begin cmd_type = T_MRR; cmd_addr = 8'd0; end
      default: cmd_type = T_NORM;
    endcase
  end

  assign cmd_req = (state == S_REQ);
  assign done    = (state == S_DONE);
  assign zq_type = (state == S_REQ && step == 4'd3) ? 2'd3 :
                   (step >= 4'd3) ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state            <= S_IDLE;
      step             <= '0;
      cnt              <= '0;
      clk_en           <= 1'b0;
      cke              <= 1'b0;
      id_mfr           <= '0;
      id_rev           <= '0;
      id_org           <= '0;
      id_info          <= '0;
      refresh_en       <= 1'b0;
      refresh_interval <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_REQ;
          step  <= '0;
        end
        S_REQ: if (cmd_ack) begin
          if (step == 4'd0) clk_en <= 1'b1;
          if (step == 4'd1) cke    <= 1'b1;
          if (step == 4'd9)  id_mfr  <= cmd_rdata;
          if (step == 4'd10) id_rev  <= cmd_rdata;
          if (step == 4'd11) id_org  <= cmd_rdata;
          if (step == 4'd12) id_info <= cmd_rdata;
          if (step == 4'(LAST)) begin
            state            <= S_DONE;
            refresh_en       <= 1'b1;
            refresh_interval <= cfg_refi;
          end else if (wait_len != '0) begin
            state <= S_WAIT;
            cnt   <= wait_len - 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_WAIT: if (cnt == '0) begin
          state <= S_REQ;
          step  <= step + 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !cmd_req && !done && !cke); // R1
  AST_CKE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> clk_en); // R2
  AST_ZQ_INIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_type == T_MRW && cmd_addr == 8'd10) |-> zq_type == 2'd3); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> cmd_req && $stable(cmd_type) && $stable(cmd_addr) && $stable(cmd_wdata)); // R6
  AST_REFRESH_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en |-> done); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !cmd_req); // R10

endmodule

// File: tb/lpddr2_bringup_bench.sv
module lpddr2_bringup_bench;
  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] cfg_mr1 = 0, cfg_mr2 = 0, cfg_mr3 = 0, cfg_mr16 = 0;
  logic [15:0] cfg_refi = 0;
  logic cmd_req, cmd_ack = 0;
  logic [1:0] cmd_type, zq_type;
  logic [7:0] cmd_addr, cmd_wdata, cmd_rdata = 0;
  logic clk_en, cke, done, refresh_en;
  logic [7:0] id_mfr, id_rev, id_org, id_info;
  logic [15:0] refresh_interval;

  lpddr2_bringup u_lpddr2_bringup (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  int ack_delay = 0;
  int n_log = 0, hold_err = 0;
  int l_type[16], l_addr[16], l_data[16], l_req[16], l_ack[16];
  int l_clken[16], l_cke[16], l_zq[16], l_ref[16];

  localparam int E_CKE = (100 * 100 + 999) / 1000;
  localparam int E_RST = (200000 * 100 + 999) / 1000;
  localparam int E_INIT5 = (10000 * 100 + 999) / 1000;
  localparam int E_ZQ = (1000 * 100 + 999) / 1000;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  initial begin : responder
    bit pend = 0;
    int wn = 0, rc = 0;
    logic [1:0] ft;
    logic [7:0] fa, fd;
    forever begin
      @(negedge clk);
      if (cmd_ack) cmd_ack = 0;
      else if (cmd_req) begin
        if (!pend) begin
          pend = 1; rc = cyc; wn = ack_delay;
          ft = cmd_type; fa = cmd_addr; fd = cmd_wdata;
        end else if (cmd_type !== ft || cmd_addr !== fa || cmd_wdata !== fd) hold_err++;
        if (wn == 0) begin
          if (n_log < 16) begin
            l_type[n_log] = cmd_type; l_addr[n_log] = cmd_addr; l_data[n_log] = cmd_wdata;
            l_req[n_log] = rc; l_ack[n_log] = cyc + 1;
            l_clken[n_log] = clk_en; l_cke[n_log] = cke; l_zq[n_log] = zq_type;
            l_ref[n_log] = refresh_en;
          end
          n_log++;
          cmd_rdata = cmd_addr ^ 8'hA5;
          cmd_ack = 1;
          pend = 0;
        end else wn--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic do_reset();
    rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    n_log = 0; hold_err = 0;
  endtask

  task automatic test_reset_state();
    do_reset();
    repeat (20) @(negedge clk);
    chk(!cmd_req && n_log == 0, "R1", "no request before start", cmd_req, 0);
    chk({clk_en, cke, done, refresh_en} == 4'b0, "R1", "flags after reset", {clk_en, cke, done, refresh_en}, 0);
    chk(refresh_interval == 0 && zq_type == 0, "R1", "interval/zq after reset", refresh_interval, 0);
    chk({id_mfr, id_rev, id_org, id_info} == 32'b0, "R1", "ids after reset", {id_mfr, id_rev, id_org, id_info}, 0);
  endtask

  task automatic run_seq(input int dly, input logic [7:0] m1, m2, m3, m16, input logic [15:0] refi);
    int et[14] = '{0,0,1,1,1,1,1,1,0,2,2,2,2,3};
    int ea[14] = '{0,0,63,10,1,2,3,16,0,5,6,8,0,0};
    int ed[14];
    ed = '{0,0,0,255,int'(m1),int'(m2),int'(m3),int'(m16),0,0,0,0,0,0};
    do_reset();
    ack_delay = dly;
    cfg_mr1 = m1; cfg_mr2 = m2; cfg_mr3 = m3; cfg_mr16 = m16; cfg_refi = refi;
    start = 1; @(negedge clk); start = 0;
    while (n_log < 3) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(n_log == 14, "R8", "command count", n_log, 14);
    for (int i = 0; i < 14; i++) begin
      string rq;
      rq = (i < 2) ? "R2" : (i == 2) ? "R3" : (i == 3) ? "R4" : (i < 8) ? "R5" : (i < 13) ? "R7" : "R8";
      chk(l_type[i] == et[i], rq, $sformatf("type of cmd %0d", i), l_type[i], et[i]);
      chk(l_addr[i] == ea[i], rq, $sformatf("addr of cmd %0d", i), l_addr[i], ea[i]);
      chk(l_data[i] == ed[i], rq, $sformatf("data of cmd %0d", i), l_data[i], ed[i]);
      chk(l_ref[i] == 0, "R9", $sformatf("refresh_en during cmd %0d", i), l_ref[i], 0);
    end
    chk(l_clken[0] == 0 && l_clken[1] == 1, "R2", "clk_en rises at first ack", l_clken[1], 1);
    chk(l_cke[1] == 0 && l_cke[2] == 1, "R2", "cke rises at second ack", l_cke[2], 1);
    chk(l_req[1] - l_ack[0] >= E_CKE && l_req[1] - l_ack[0] <= E_CKE + 1, "R11", "clock-start to CKE gap", l_req[1] - l_ack[0], E_CKE);
    chk(l_req[2] - l_ack[1] >= E_RST && l_req[2] - l_ack[1] <= E_RST + 1, "R3", "CKE to reset gap", l_req[2] - l_ack[1], E_RST);
    chk(l_req[3] - l_ack[2] >= E_INIT5 && l_req[3] - l_ack[2] <= E_INIT5 + 1, "R3", "tINIT5 gap", l_req[3] - l_ack[2], E_INIT5);
    chk(l_req[4] - l_ack[3] >= E_ZQ && l_req[4] - l_ack[3] <= E_ZQ + 1, "R4", "tZQINIT gap", l_req[4] - l_ack[3], E_ZQ);
    chk(l_zq[3] == 3, "R4", "zq code during calibration", l_zq[3], 3);
    chk(l_zq[4] == 2 && zq_type == 2, "R4", "zq code after calibration", l_zq[4], 2);
    chk(hold_err == 0, "R6", "request fields held until ack", hold_err, 0);
    chk(id_mfr == (8'd5 ^ 8'hA5), "R7", "MR5 capture", id_mfr, 8'd5 ^ 8'hA5);
    chk(id_rev == (8'd6 ^ 8'hA5), "R7", "MR6 capture", id_rev, 8'd6 ^ 8'hA5);
    chk(id_org == (8'd8 ^ 8'hA5), "R7", "MR8 capture", id_org, 8'd8 ^ 8'hA5);
    chk(id_info == (8'd0 ^ 8'hA5), "R7", "MR0 capture", id_info, 8'hA5);
    chk(refresh_en && refresh_interval == refi, "R8", "refresh loaded", refresh_interval, refi);
    start = 1; @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    chk(done && !cmd_req && n_log == 14, "R10", "start after done ignored", n_log, 14);
  endtask

  initial begin
    test_reset_state();
    run_seq(0, 8'h42, 8'h06, 8'h02, 8'h00, 16'd780);
    run_seq(3, 8'h23, 8'h04, 8'h01, 8'hF0, 16'd1234);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule